// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial flash command from a single 32-bit control word. The word names an opcode and, optionally, an address of one to four bytes, a count of idle dummy clock slots, up to eight bytes of outgoing data and up to eight bytes of incoming data. Software presents the address and two 32-bit outgoing data words on their inputs, then writes the control word with its execute bit set. The block samples everything on that edge and drives the command out one bit per clock on a single data line, with chip-select held low throughout. Read bytes are collected from the input line into a pair of 32-bit result words.

The serial clock is a fixed enable: every clock cycle while a command runs is one bit slot, and `sclk_en` marks those slots. Clock division, multi-line transfers and the register bus that would hold the words are outside this block. Software polls `in_prog` until it drops, then reads `rd_lo` and `rd_hi`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `cs_n` is 1, `in_prog` is 0, `mosi` is 0 and both result words are zero.
- R2: A `cmd_wr` pulse whose word has bit 0 set while idle starts a command: in the next cycle `in_prog` is 1, `cs_n` is 0, and the first eight bit slots carry the opcode from bits 31:24, most significant bit first.
- R3: When bit 19 is set, bits 17:16 hold the address length minus one; the low (value+1) bytes of `cmd_addr` follow the opcode, highest of those bytes first, each byte MSB first.
- R4: Bits 11:7 give the number of dummy slots, during which `mosi` is 0; a value of 0 inserts none.
- R5: When bit 15 is set, bits 14:12 hold the write length minus one; data byte k (bytes 0 to 3 in `wr_lo` with byte 0 at bits 7:0, bytes 4 to 7 in `wr_hi`) is sent in order k = 0 upward, each byte MSB first.
- R6: When bit 23 is set, bits 22:20 hold the read length minus one; byte k of the incoming stream (MSB first) lands in the same byte position of {`rd_hi`,`rd_lo`}, and bytes at or beyond the read length keep their old values; `mosi` is 0 during read slots.
- R7: The phases run in the order opcode, address, dummy, write data, read data, skipping any that are disabled.
- R8: `cs_n` is low and `sclk_en` high for exactly the number of bit slots of the command; one cycle after the last slot `cs_n` returns to 1 and `in_prog` to 0.
- R9: A `cmd_wr` with the execute bit set during a command has no effect on the running command and starts nothing afterwards.
- R10: A `cmd_wr` whose word has bit 0 clear starts nothing.
- R11: A command without bit 23 set leaves both result words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Control word write strobe |
| cmd_word | input | 32 | Control word |
| cmd_addr | input | 32 | Address value, sampled at start |
| wr_lo | input | 32 | Outgoing data bytes 0 to 3 |
| wr_hi | input | 32 | Outgoing data bytes 4 to 7 |
| miso | input | 1 | Serial data in, sampled at the end of a read slot |
| in_prog | output | 1 | Command in progress |
| cs_n | output | 1 | Active-low chip-select |
| sclk_en | output | 1 | Marks a bit slot |
| mosi | output | 1 | Serial data out |
| rd_lo | output | 32 | Incoming data bytes 0 to 3 |
| rd_hi | output | 32 | Incoming data bytes 4 to 7 |

## Verification
The first opcode bit appears in the cycle right after the execute edge, and a command of N slots holds `cs_n` low for cycles 1 to N, with `cs_n` high and `in_prog` low in cycle N+1, when the last read byte is already in the result words. The bench drives and samples only at falling edges: it records `mosi` and sets `miso` for the slot of that cycle, counts slots until chip-select rises, and compares the count against N computed from the control word. Result words are compared once `in_prog` is low, against a model that replaces only the bytes the read length covers.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic [31:0] cmd_addr,
  input  logic [31:0] wr_lo,
  input  logic [31:0] wr_hi,
  input  logic        miso,
  output logic        in_prog,
  output logic        cs_n,
  output logic        sclk_en,
  output logic        mosi,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi
);
  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_DUM, S_WRD, S_RDD} st_t;

  st_t         st, nxt;
  logic [63:0] sr;
  logic [5:0]  cnt;
  logic [5:0]  rxi;
  logic [6:0]  rb;
  logic [31:0] q_ctl, q_addr;
  logic [63:0] q_wd;
  logic [63:0] rd;

  wire [4:0] q_dum = q_ctl[11:7];
  wire [2:0] q_nw  = q_ctl[14:12];
  wire       q_wen = q_ctl[15];
  wire [1:0] q_na  = q_ctl[17:16];
  wire       q_aen = q_ctl[19];
  wire [2:0] q_nr  = q_ctl[22:20];
  wire       q_ren = q_ctl[23];

  wire start = cmd_wr && cmd_word[0] && (st == S_IDLE);
  wire last  = (cnt == 6'd0);

  st_t after_wr, after_dum, after_adr, after_opc;
  assign after_wr  = q_ren ? S_RDD : S_IDLE;
  assign after_dum = q_wen ? S_WRD : after_wr;
  assign after_adr = (q_dum != 5'd0) ? S_DUM : after_dum;
  assign after_opc = q_aen ? S_ADR : after_adr;

  always_comb begin
    case (st)
      S_OPC:   nxt = after_opc;
      S_ADR:   nxt = after_adr;
      S_DUM:   nxt = after_dum;
      S_WRD:   nxt = after_wr;
      default: nxt = S_IDLE;
    endcase
  end

  logic [31:0] aseq;
  logic [63:0] wseq;
  assign aseq = q_addr << {(2'd3 - q_na), 3'b000};

  always_comb begin
    for (int i = 0; i < 8; i++)
      wseq[63-8*i -: 8] = q_wd[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sr     <= '0;
      cnt    <= '0;
      rxi    <= '0;
      rb     <= '0;
      q_ctl  <= '0;
      q_addr <= '0;
      q_wd   <= '0;
      rd     <= '0;
    end else if (start) begin
      st     <= S_OPC;
      q_ctl  <= cmd_word;
      q_addr <= cmd_addr;
      q_wd   <= {wr_hi, wr_lo};
      sr     <= {cmd_word[31:24], 56'd0};
      cnt    <= 6'd7;
      rxi    <= '0;
    end else if (st != S_IDLE) begin
      if (st == S_RDD) begin
        rb  <= {rb[5:0], miso};
        if (rxi[2:0] == 3'd7)
          rd[{rxi[5:3], 3'b000} +: 8] <= {rb, miso};
        rxi <= rxi + 6'd1;
      end
      if (!last) begin
        sr  <= sr << 1;
        cnt <= cnt - 6'd1;
      end else begin
        st <= nxt;
        case (nxt)
          S_ADR: begin
            sr  <= {aseq, 32'd0};
            cnt <= {1'b0, q_na, 3'b111};
          end
          S_DUM:   cnt <= {1'b0, q_dum} - 6'd1;
          S_WRD: begin
            sr  <= wseq;
            cnt <= {q_nw, 3'b111};
          end
          S_RDD:   cnt <= {q_nr, 3'b111};
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign in_prog = (st != S_IDLE);
  assign cs_n    = !in_prog;
  assign sclk_en = in_prog;
  assign mosi    = (st == S_OPC || st == S_ADR || st == S_WRD) ? sr[63] : 1'b0;
  assign rd_lo   = rd[31:0];
  assign rd_hi   = rd[63:32];

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[0] && !in_prog) |=> (in_prog && !cs_n));

  p_busy_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && cmd_wr) |=> $stable(q_ctl));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_prog |=> $stable(rd));

  p_noread_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && !q_ren) |=> $stable(rd));

  p_dummy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DUM || st == S_RDD) |-> !mosi);

  p_noexec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_prog && !(cmd_wr && cmd_word[0])) |=> !in_prog);
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_wr = 0;
  logic [31:0] cmd_word = 0, cmd_addr = 0, wr_lo = 0, wr_hi = 0;
  logic        miso = 0;
  logic        in_prog, cs_n, sclk_en, mosi;
  logic [31:0] rd_lo, rd_hi;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_rd = 0;

  always #4 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .cmd_addr(cmd_addr), .wr_lo(wr_lo), .wr_hi(wr_hi), .miso(miso),
    .in_prog(in_prog), .cs_n(cs_n), .sclk_en(sclk_en), .mosi(mosi),
    .rd_lo(rd_lo), .rd_hi(rd_hi));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input bit ren, input int nr,
      input bit aen, input int na, input bit wen, input int nw, input int dum);
    logic [31:0] w;
    w = 32'd1;
    w[31:24] = op;
    w[23] = ren;    w[22:20] = 3'(nr - 1);
    w[19] = aen;    w[17:16] = 2'(na - 1);
    w[15] = wen;    w[14:12] = 3'(nw - 1);
    w[11:7] = 5'(dum);
    return w;
  endfunction

  task automatic run(input logic [31:0] w, input logic [31:0] a, input logic [63:0] wd,
                     input logic [63:0] rx, input bit inj, input string req);
    int na, nd, nw, nr, n, rs, idx, cnt, mism, gaps;
    logic [255:0] ev;
    na = w[19] ? int'(w[17:16]) + 1 : 0;
    nd = int'(w[11:7]);
    nw = w[15] ? int'(w[14:12]) + 1 : 0;
    nr = w[23] ? int'(w[22:20]) + 1 : 0;
    n  = 8 + 8*na + nd + 8*nw + 8*nr;
    rs = 8 + 8*na + nd + 8*nw;
    ev = '0; idx = 0;
    for (int b = 7; b >= 0; b--) begin ev[idx] = w[24+b]; idx++; end
    for (int k = na-1; k >= 0; k--)
      for (int b = 7; b >= 0; b--) begin ev[idx] = a[8*k+b]; idx++; end
    idx += nd;
    for (int k = 0; k < nw; k++)
      for (int b = 7; b >= 0; b--) begin ev[idx] = wd[8*k+b]; idx++; end

    @(negedge clk);
    cmd_word = w; cmd_addr = a; wr_lo = wd[31:0]; wr_hi = wd[63:32]; cmd_wr = 1;
    @(negedge clk);
    cmd_wr = 0;
    chk(in_prog === 1'b1 && cs_n === 1'b0, "R2", "start flags", {62'd0, in_prog, cs_n}, 64'd2);
    cnt = 0; mism = 0; gaps = 0;
    while (cs_n === 1'b0 && cnt < 300) begin
      if (mosi !== ev[cnt]) mism++;
      if (sclk_en !== 1'b1) gaps++;
      miso = (cnt >= rs) ? rx[8*((cnt-rs)/8) + 7 - ((cnt-rs)%8)] : 1'b0;
      if (inj && cnt == 3) begin cmd_word = 32'hC3FF_FFFF; cmd_wr = 1; end
      else cmd_wr = 0;
      cnt++;
      @(negedge clk);
    end
    cmd_wr = 0; miso = 0;
    chk(mism == 0, req, "mosi stream mismatches (R7)", 64'(mism), 64'd0);
    chk(cnt == n && gaps == 0, "R8", "slot count", 64'(cnt), 64'(n));
    chk(in_prog === 1'b0 && cs_n === 1'b1, "R8", "release", {62'd0, in_prog, cs_n}, 64'd1);
    for (int k = 0; k < nr; k++) exp_rd[8*k +: 8] = rx[8*k +: 8];
    chk({rd_hi, rd_lo} === exp_rd, nr > 0 ? "R6" : "R11", "result words", {rd_hi, rd_lo}, exp_rd);
    if (inj) begin
      @(negedge clk); @(negedge clk);
      chk(cs_n === 1'b1 && in_prog === 1'b0, "R9", "no late start", {62'd0, in_prog, cs_n}, 64'd1);
    end
  endtask

  initial begin
    #(8*150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    #2;
    @(negedge clk);
    chk(cs_n === 1'b1 && in_prog === 1'b0 && mosi === 1'b0, "R1", "reset outputs",
        {61'd0, cs_n, in_prog, mosi}, 64'd4);
    chk({rd_hi, rd_lo} === 64'd0, "R1", "reset results", {rd_hi, rd_lo}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    cmd_word = mk(8'h9F, 1, 3, 0, 1, 0, 1, 0) & 32'hFFFF_FFFE; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    @(negedge clk); @(negedge clk);
    chk(cs_n === 1'b1 && in_prog === 1'b0, "R10", "no start without execute",
        {62'd0, in_prog, cs_n}, 64'd1);

    run(mk(8'h06, 0, 1, 0, 1, 0, 1, 0), 0, 0, 0, 0, "R2");
    run(mk(8'hA5, 0, 1, 0, 1, 0, 1, 0), 0, 0, 0, 0, "R2");

    for (int nr = 1; nr <= 8; nr++) begin
      pat = 64'h0123_4567_89AB_CDEF ^ {8{8'(nr * 37)}};
      run(mk(8'h9F, 1, nr, 0, 1, 0, 1, 0), 0, 0, pat, 0, "R6");
    end
    for (int nw = 1; nw <= 8; nw++)
      run(mk(8'h01, 0, 1, 0, 1, 1, nw, 0), 0, 64'hF0E1_D2C3_B4A5_9687 + 64'(nw), 0, 0, "R5");
    for (int na = 1; na <= 4; na++)
      run(mk(8'hD8, 0, 1, 1, na, 0, 1, 0), 32'hA1B2_C3D4, 0, 0, 0, "R3");
    run(mk(8'h5A, 0, 1, 0, 1, 0, 1, 1), 0, 0, 0, 0, "R4");
    run(mk(8'h5A, 0, 1, 0, 1, 0, 1, 8), 0, 0, 0, 0, "R4");
    run(mk(8'h5A, 0, 1, 0, 1, 0, 1, 31), 0, 0, 0, 0, "R4");
    run(mk(8'h0B, 1, 8, 1, 3, 0, 1, 8), 32'h0012_3456, 0, 64'hDEAD_BEEF_CAFE_F00D, 0, "R7");
    run(mk(8'h02, 0, 1, 1, 4, 1, 5, 0), 32'h7654_3210, 64'h1122_3344_5566_7788, 0, 0, "R7");
    run(mk(8'h4B, 1, 2, 1, 2, 1, 3, 4), 32'h0000_BEEF, 64'h0000_0000_00C0_FFEE,
        64'h5555_5555_5555_A33C, 0, "R7");
    run(mk(8'h3C, 1, 4, 0, 1, 0, 1, 0), 0, 0, 64'h0F1E_2D3C_4B5A_6978, 1, "R9");
    run(mk(8'h04, 0, 1, 0, 1, 0, 1, 0), 0, 0, 0, 0, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule